// File: doc/BRIEF.md
# Four-Lane Same-Address Update Coalescer

This block sits in front of a four-lane counter update engine. Every cycle each lane may present one update request made of a valid bit, a counter address and a 72-bit increment word. The increment word holds a packet increment and a byte increment. Before any request reaches the read-modify-write engine, the block removes every address collision that could let two in-flight accesses touch the same counter location.

The first stage looks across the four lanes of one cycle. When several valid lanes name the same address, the highest-priority lane among them keeps its valid bit and carries the field-wise sum of all their increments. The other matching lanes are dropped. The second stage looks along each lane in time. It compares each surviving request with the request that left the same lane one cycle earlier, and raises a per-lane back-to-back flag when both target the same address. The engine uses that flag to forward its previous result instead of reading memory again. The pipeline is fixed at two cycles and never stalls.

Top module: `stats_coalesce`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, every bit of `outValid` and `outB2b` is 0.
- R2: A request presented on lane i whose address no other valid lane shares in that cycle appears on lane i of the outputs exactly two clock edges later, with the same address and increment word.
- R3: An input lane with valid 0 never yields an output valid of 1 two cycles later. Its address takes no part in matching, so it cannot suppress or absorb a valid request on any other lane.
- R4: When two or more valid lanes share an address in one cycle, only the lowest-numbered of them (lane 0 has top priority, lane 3 the lowest) is output valid. It carries the sum of the increments of all matching lanes, and the others output valid 0.
- R5: In the increment word, bits [71:40] are the packet field and bits [39:0] are the byte field. Merged fields are summed independently and wrap modulo their width, and a carry out of the byte field never reaches the packet field.
- R6: `outB2b[i]` is 1 exactly when output lane i is valid, output lane i was valid in the previous cycle, and both carry the same address. The comparison uses the requests as they stand after merging.
- R7: A matching address on a different lane in the previous cycle does not raise the back-to-back flag.
- R8: In any cycle, no two valid output lanes carry the same address.
- R9: Output lane 0 is valid exactly when input lane 0 was valid two cycles earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 4 | Per-lane request valid, bit i is lane i |
| inAddr | input | 4*ADDR_W | Per-lane counter address, lane i at [i*ADDR_W +: ADDR_W] |
| inInc | input | 288 | Per-lane increment word, lane i at [i*72 +: 72] |
| outValid | output | 4 | Per-lane valid after coalescing |
| outAddr | output | 4*ADDR_W | Per-lane address, same packing as inAddr |
| outInc | output | 288 | Per-lane merged increment word, same packing as inInc |
| outB2b | output | 4 | Per-lane back-to-back same-address flag |

## Verification
The hardest case to reach is a lane whose previous request was absorbed by a higher-priority lane and which then receives that same address again. The correct flag is 0 on the absorbed lane and 1 on the absorbing lane. That holds only if the back-to-back comparison uses merged requests rather than raw inputs. The bench builds this case with two directed consecutive cycles. It then runs a long random stretch over only four addresses, so that same-cycle merges, back-to-back hits and absorbed predecessors overlap in many combinations. A reference model written from the requirements scores every cycle.

// File: rtl/stats_coalesce_pkg.sv
package stats_coalesce_pkg;

  localparam int NUM_LANES = 4;
  localparam int PKT_W     = 32;
  localparam int BYTE_W    = 40;
  localparam int WORD_W    = PKT_W + BYTE_W;

  typedef logic [WORD_W-1:0] cntWord_t;

  // Strobes passed from the compare logic to the datapath.
  typedef struct packed {
    logic [NUM_LANES-1:0]                keep;      // lane survives same-cycle merge
    logic [NUM_LANES-1:0][NUM_LANES-1:0] mergeSel;  // [i][k]: lane k folds into lane i
    logic [NUM_LANES-1:0]                b2b;       // stage-2 same-lane repeat
  } coalesceStrobes_t;

  // Field-wise add: packet and byte parts wrap on their own.
  function automatic cntWord_t addWords(input cntWord_t a, input cntWord_t b);
    logic [PKT_W-1:0]  pktSum;
    logic [BYTE_W-1:0] byteSum;
    pktSum  = a[WORD_W-1:BYTE_W] + b[WORD_W-1:BYTE_W];
    byteSum = a[BYTE_W-1:0] + b[BYTE_W-1:0];
    return {pktSum, byteSum};
  endfunction

endpackage

// File: rtl/coalesce_ctrl.sv
module coalesce_ctrl
  import stats_coalesce_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [NUM_LANES-1:0]             inValid,
  input  logic [NUM_LANES-1:0][ADDR_W-1:0] inAddr,
  input  logic [NUM_LANES-1:0]             s1Valid,
  input  logic [NUM_LANES-1:0][ADDR_W-1:0] s1Addr,
  input  logic [NUM_LANES-1:0]             outValid,
  input  logic [NUM_LANES-1:0][ADDR_W-1:0] outAddr,
  output coalesceStrobes_t                 strb
);

  // Pairwise match matrix between valid lanes of the current cycle.
  logic [NUM_LANES-1:0][NUM_LANES-1:0] laneMatch;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_row
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_col
      assign laneMatch[i][k] = inValid[i] && inValid[k] && (inAddr[i] == inAddr[k]);
    end
  end

  always_comb begin
    strb = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      strb.keep[i] = inValid[i];
      for (int k = 0; k < NUM_LANES; k++) begin
        if (k < i && laneMatch[i][k]) begin
          strb.keep[i] = 1'b0;          // a higher-priority lane owns it
        end
        if (k >= i) begin
          strb.mergeSel[i][k] = laneMatch[i][k];
        end
      end
      // Stage 2: merged request against the one that left this lane last cycle.
      strb.b2b[i] = s1Valid[i] && outValid[i] && (s1Addr[i] == outAddr[i]);
    end
  end

endmodule

// File: rtl/coalesce_lane_sum.sv
module coalesce_lane_sum
  import stats_coalesce_pkg::*;
(
  input  logic [NUM_LANES-1:0]  sel,
  input  cntWord_t              incs [NUM_LANES],
  output cntWord_t              sum
);

  always_comb begin
    sum = '0;
    for (int k = 0; k < NUM_LANES; k++) begin
      if (sel[k]) begin
        sum = addWords(sum, incs[k]);
      end
    end
  end

endmodule

// File: rtl/coalesce_data.sv
module coalesce_data
  import stats_coalesce_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_LANES-1:0][ADDR_W-1:0] inAddr,
  input  cntWord_t                         inInc [NUM_LANES],
  input  coalesceStrobes_t                 strb,
  output logic [NUM_LANES-1:0]             s1Valid,
  output logic [NUM_LANES-1:0][ADDR_W-1:0] s1Addr,
  output logic [NUM_LANES-1:0]             outValid,
  output logic [NUM_LANES-1:0][ADDR_W-1:0] outAddr,
  output cntWord_t                         outInc [NUM_LANES],
  output logic [NUM_LANES-1:0]             outB2b
);

  cntWord_t laneSum [NUM_LANES];
  cntWord_t s1Inc   [NUM_LANES];

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_sum
    coalesce_lane_sum u_sum (
      .sel  (strb.mergeSel[i]),
      .incs (inInc),
      .sum  (laneSum[i])
    );
  end

  // Stage 1: same-cycle merge result.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= '0;
      s1Addr  <= '0;
      for (int i = 0; i < NUM_LANES; i++) s1Inc[i] <= '0;
    end else begin
      s1Valid <= strb.keep;
      s1Addr  <= inAddr;
      for (int i = 0; i < NUM_LANES; i++) s1Inc[i] <= laneSum[i];
    end
  end

  // Stage 2: same-lane repeat flag and output register.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= '0;
      outAddr  <= '0;
      outB2b   <= '0;
      for (int i = 0; i < NUM_LANES; i++) outInc[i] <= '0;
    end else begin
      outValid <= s1Valid;
      outAddr  <= s1Addr;
      outB2b   <= strb.b2b;
      for (int i = 0; i < NUM_LANES; i++) outInc[i] <= s1Inc[i];
    end
  end

endmodule

// File: rtl/stats_coalesce.sv
module stats_coalesce
  import stats_coalesce_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_LANES-1:0]          inValid,
  input  logic [NUM_LANES*ADDR_W-1:0]   inAddr,
  input  logic [NUM_LANES*WORD_W-1:0]   inInc,
  output logic [NUM_LANES-1:0]          outValid,
  output logic [NUM_LANES*ADDR_W-1:0]   outAddr,
  output logic [NUM_LANES*WORD_W-1:0]   outInc,
  output logic [NUM_LANES-1:0]          outB2b
);

  logic [NUM_LANES-1:0][ADDR_W-1:0] inAddrArr;
  logic [NUM_LANES-1:0][ADDR_W-1:0] s1Addr;
  logic [NUM_LANES-1:0][ADDR_W-1:0] outAddrArr;
  logic [NUM_LANES-1:0]             s1Valid;
  cntWord_t                         inIncArr  [NUM_LANES];
  cntWord_t                         outIncArr [NUM_LANES];
  coalesceStrobes_t                 strb;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_pack
    assign inAddrArr[i]                 = inAddr[i*ADDR_W +: ADDR_W];
    assign inIncArr[i]                  = inInc[i*WORD_W +: WORD_W];
    assign outAddr[i*ADDR_W +: ADDR_W]  = outAddrArr[i];
    assign outInc[i*WORD_W +: WORD_W]   = outIncArr[i];
  end

  coalesce_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .inValid  (inValid),
    .inAddr   (inAddrArr),
    .s1Valid  (s1Valid),
    .s1Addr   (s1Addr),
    .outValid (outValid),
    .outAddr  (outAddrArr),
    .strb     (strb)
  );

  coalesce_data #(.ADDR_W(ADDR_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .inAddr   (inAddrArr),
    .inInc    (inIncArr),
    .strb     (strb),
    .s1Valid  (s1Valid),
    .s1Addr   (s1Addr),
    .outValid (outValid),
    .outAddr  (outAddrArr),
    .outInc   (outIncArr),
    .outB2b   (outB2b)
  );

endmodule

// File: rtl/stats_coalesce_chk.sv
module stats_coalesce_chk
  import stats_coalesce_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_LANES-1:0]        inValid,
  input logic [NUM_LANES-1:0]        outValid,
  input logic [NUM_LANES*ADDR_W-1:0] outAddr,
  input logic [NUM_LANES-1:0]        outB2b
);

  // Edges seen since reset release, saturating at 3.
  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    // R3
    valid_source_chk: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst == 2'd3 && outValid[i]) |-> $past(inValid[i], 2));

    // R6
    b2b_match_chk: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst != 2'd0) |->
        (outB2b[i] == (outValid[i] && $past(outValid[i]) &&
                       outAddr[i*ADDR_W +: ADDR_W] == $past(outAddr[i*ADDR_W +: ADDR_W]))));

    for (genvar j = i + 1; j < NUM_LANES; j++) begin : g_pair
      // R8
      unique_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
        (outValid[i] && outValid[j]) |->
          (outAddr[i*ADDR_W +: ADDR_W] != outAddr[j*ADDR_W +: ADDR_W]));
    end
  end

  // R9
  lane0_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid[0] == $past(inValid[0], 2)));

endmodule

bind stats_coalesce stats_coalesce_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .outValid (outValid),
  .outAddr  (outAddr),
  .outB2b   (outB2b)
);

// File: tb/stats_coalesce_bench.sv
`timescale 1ns/1ps
module stats_coalesce_bench;
  import stats_coalesce_pkg::*;

  localparam int AW = 20;
  localparam int L  = NUM_LANES;

  logic                clk = 1'b0;
  logic                rstN;
  logic [L-1:0]        inValid;
  logic [L*AW-1:0]     inAddr;
  logic [L*WORD_W-1:0] inInc;
  logic [L-1:0]        outValid;
  logic [L*AW-1:0]     outAddr;
  logic [L*WORD_W-1:0] outInc;
  logic [L-1:0]        outB2b;

  always #2 clk = ~clk;

  stats_coalesce #(.ADDR_W(AW)) u_stats_coalesce (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inAddr(inAddr), .inInc(inInc),
    .outValid(outValid), .outAddr(outAddr), .outInc(outInc), .outB2b(outB2b)
  );

  typedef struct {
    logic [L-1:0]             v;
    logic [L-1:0]             b2b;
    logic [L-1:0][AW-1:0]     a;
    logic [L-1:0][WORD_W-1:0] w;
    string                    tag;
  } expItem_t;

  expItem_t expQ[$];
  int testsRun = 0;
  int testsFailed = 0;
  logic [L-1:0]         prevV = '0;
  logic [L-1:0][AW-1:0] prevA = '0;
  logic [L-1:0][AW-1:0]     stA;
  logic [L-1:0][WORD_W-1:0] stW;
  bit done = 0;

  function automatic logic [WORD_W-1:0] mk(input logic [PKT_W-1:0] p, input logic [BYTE_W-1:0] b);
    return {p, b};
  endfunction

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic driveCycle(input logic [L-1:0] v, input string tag);
    expItem_t e;
    @(negedge clk);
    inValid = v;
    for (int i = 0; i < L; i++) begin
      inAddr[i*AW +: AW]         = stA[i];
      inInc[i*WORD_W +: WORD_W]  = stW[i];
    end
    e.tag = tag;
    for (int i = 0; i < L; i++) begin
      logic [PKT_W-1:0]  p;
      logic [BYTE_W-1:0] b;
      e.v[i] = v[i];
      for (int j = 0; j < i; j++)
        if (v[j] && stA[j] == stA[i]) e.v[i] = 1'b0;
      p = '0; b = '0;
      for (int k = i; k < L; k++)
        if (v[k] && stA[k] == stA[i]) begin
          p = p + stW[k][WORD_W-1:BYTE_W];
          b = b + stW[k][BYTE_W-1:0];
        end
      e.a[i]   = stA[i];
      e.w[i]   = {p, b};
      e.b2b[i] = e.v[i] && prevV[i] && prevA[i] == stA[i];
    end
    prevV = e.v;
    prevA = e.a;
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) driveCycle('0, "idle R3");
  endtask

  // Monitor: output for the item pushed two negedges ago is stable now.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() >= 3) begin
        expItem_t e;
        bit bad;
        e = expQ.pop_front();
        testsRun++;
        bad = 0;
        for (int i = 0; i < L; i++) begin
          logic [AW-1:0]     ga;
          logic [WORD_W-1:0] gw;
          ga = outAddr[i*AW +: AW];
          gw = outInc[i*WORD_W +: WORD_W];
          if (!bad && (outValid[i] !== e.v[i] || outB2b[i] !== e.b2b[i] ||
              (e.v[i] && (ga !== e.a[i] || gw !== e.w[i])))) begin
            bad = 1;
            $display("FAIL %s lane %0d: got v=%b b2b=%b addr=%h inc=%h, expected v=%b b2b=%b addr=%h inc=%h",
                     e.tag, i, outValid[i], outB2b[i], ga, gw, e.v[i], e.b2b[i], e.a[i], e.w[i]);
          end
        end
        if (bad) testsFailed++;
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = '0; inAddr = '0; inInc = '0;
    stA = '0; stW = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet during reset
    testsRun++;
    if (outValid !== '0 || outB2b !== '0) begin
      testsFailed++;
      $display("FAIL R1 in reset: got v=%b b2b=%b, expected 0 0", outValid, outB2b);
    end
    rstN = 1'b1;
    @(posedge clk);
    #1;
    testsRun++;
    if (outValid !== '0 || outB2b !== '0) begin
      testsFailed++;
      $display("FAIL R1 after release: got v=%b b2b=%b, expected 0 0", outValid, outB2b);
    end

    // R2: distinct addresses pass through unchanged
    for (int c = 0; c < 3; c++) begin
      for (int i = 0; i < L; i++) begin
        stA[i] = AW'(16 * c + i + 1);
        stW[i] = mk(PKT_W'(c + 1), BYTE_W'(64 * (i + 1)));
      end
      driveCycle(4'b1111, "R2 distinct");
    end
    idle(1);

    // R3: invalid lane 0 shares address with lane 1, must not suppress it
    stA = '{default: AW'(7)};
    stW[0] = mk(32'd9, 40'd900); stW[1] = mk(32'd1, 40'd60);
    stW[2] = mk(32'd2, 40'd70);  stW[3] = mk(32'd3, 40'd80);
    driveCycle(4'b0010, "R3 invalid lane0 same addr");
    driveCycle(4'b0000, "R3 all invalid");
    driveCycle(4'b1010, "R3 R9 partial");
    idle(1);

    // R4: all four lanes collide
    stA = '{default: AW'(33)};
    for (int i = 0; i < L; i++) stW[i] = mk(PKT_W'(i + 1), BYTE_W'(100 * (i + 1)));
    driveCycle(4'b1111, "R4 four-way");
    idle(1);
    // R4: lanes 1 and 3 collide, 0 and 2 distinct
    stA[0] = 20'h10; stA[1] = 20'h20; stA[2] = 20'h30; stA[3] = 20'h20;
    driveCycle(4'b1111, "R4 pair 1-3");
    // R4: two independent pairs
    stA[0] = 20'h44; stA[1] = 20'h55; stA[2] = 20'h44; stA[3] = 20'h55;
    driveCycle(4'b1111, "R4 two pairs");
    idle(1);

    // R5: byte field wrap does not carry into the packet field
    stA = '{default: AW'(91)};
    stW[0] = mk(32'hFFFF_FFFF, 40'hFF_FFFF_FFFF);
    stW[1] = mk(32'd1, 40'd1);
    driveCycle(4'b0011, "R5 field wrap");
    idle(1);

    // R6: same lane, same address, consecutive cycles
    stA[0] = 20'h100; stA[1] = 20'h101; stA[2] = 20'h102; stA[3] = 20'h103;
    stW = '{default: mk(32'd1, 40'd64)};
    driveCycle(4'b0001, "R6 first");
    driveCycle(4'b0001, "R6 repeat lane0");
    driveCycle(4'b0001, "R6 third repeat");
    idle(1);
    // R6: lane 1 absorbed by lane 0, then lane 1 alone on that address
    stA[0] = 20'h200; stA[1] = 20'h200;
    driveCycle(4'b0011, "R6 absorb");
    driveCycle(4'b0011, "R6 after absorb");
    stA[0] = 20'h201;
    driveCycle(4'b0011, "R6 absorbed predecessor");
    idle(1);

    // R7: same address on another lane next cycle
    stA[0] = 20'h300; stA[2] = 20'h301;
    driveCycle(4'b0001, "R7 lane0");
    stA[0] = 20'h302; stA[2] = 20'h300;
    driveCycle(4'b0101, "R7 moved to lane2");
    idle(1);

    // R4 R6 R8 R9: random stress on four addresses
    for (int c = 0; c < 400; c++) begin
      for (int i = 0; i < L; i++) begin
        stA[i] = AW'($urandom % 4);
        stW[i] = {PKT_W'($urandom), BYTE_W'({$urandom, $urandom})};
      end
      driveCycle(L'($urandom), "R4 R6 R8 random");
    end
    idle(3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule